// File: doc/BRIEF.md
# Load Data Align and Extend

This unit sits between a 32-bit byte-addressable data bus and the register file of a processor. On a load, it takes the whole word read from the bus, picks out the byte, halfword or word that the access names, puts its bytes in the order the selected endianness requires, and widens the result to 32 bits. Unsigned loads fill the upper bits with zeros. Signed loads copy the sign bit into them.

On a store, the unit places the register data onto the bus byte lanes that the access addresses and produces a byte strobe for each lane that is written. Accesses that are not aligned to their own size are not split across words. They are flagged, and they produce no strobes and no data.

All outputs are registered, so each result appears one clock cycle after its inputs. Endianness is chosen at run time on each access.

Top module: `ldx_align_unit`

## Requirements
- R1: The access size code `accSize` is 2'b00 for byte, 2'b01 for halfword and 2'b10 for word. Code 2'b11 is reserved and is handled as a misaligned access (see R12).
- R2: Every output is registered and reflects the inputs sampled at the previous rising clock edge. While `rstN` is low, all outputs are zero.
- R3: Lane mapping. Lane i is bits [8i+7:8i] of the bus word. In little-endian mode (`bigEndian`=0), address offset k maps to lane k. In big-endian mode, offset k maps to lane 3-k.
- R4: In big-endian mode, with memory bytes 0x12, 0x34, 0x56, 0x78 at offsets 0 to 3 (bus word 0x12345678), an unsigned halfword load returns 0x00001234 from offset 0 and 0x00005678 from offset 2.
- R5: In little-endian mode, with the same memory bytes (bus word 0x78563412), an unsigned halfword load returns 0x00003412 from offset 0 and 0x00007856 from offset 2.
- R6: A byte load returns the byte stored at the addressed offset, with the same value in either endianness mode.
- R7: An unsigned byte load clears bits [31:8] of `loadResult`. An unsigned halfword load clears bits [31:16].
- R8: A signed byte or halfword load copies the most significant bit of the loaded item into all of the upper bits of `loadResult`.
- R9: A word load returns the bus word unchanged in both endianness modes, and `signedLoad` has no effect on it.
- R10: A byte store drives exactly one strobe, for the lane of the addressed offset. It places bits [7:0] of `storeData` on that lane, and every other lane of `storeLanes` is zero.
- R11: A halfword store drives two adjacent strobes (lanes 1:0 or lanes 3:2). A word store drives all four. The least significant byte of `storeData` goes to the lane that holds the least significant byte in the selected endianness, and lanes that are not strobed are zero.
- R12: The access is flagged misaligned when it is a halfword with `addrLow`[0]=1, a word with `addrLow`!=0, or uses the reserved size code. A flagged access raises `misaligned` and drives zero on `byteStrobe`, `storeLanes` and `loadResult`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| accSize | input | 2 | Access size code (R1) |
| signedLoad | input | 1 | Sign-extend byte and halfword loads |
| addrLow | input | 2 | Byte offset of the access within the word |
| bigEndian | input | 1 | 1 selects big-endian byte order, 0 little-endian |
| readData | input | 32 | Word read from the data bus |
| storeData | input | 32 | Register data to store, item in the low bits |
| loadResult | output | 32 | Aligned and extended load value |
| storeLanes | output | 32 | Store data placed on the bus lanes |
| byteStrobe | output | 4 | Per-lane write enables, bit i for lane i |
| misaligned | output | 1 | Access is not aligned to its size |

## Verification
The strobe-shape and fill-bit assertions assume only that `accSize`, `addrLow` and `signedLoad` are known values at each rising edge while reset is high. The bench meets this by changing every input only at falling edges and never leaving an input undriven. The pass-through assertion for word loads compares against the bus word from the previous cycle, which relies on the same stable-at-edge drive. The stimulus covers every size code, both endiannesses, both sign settings, and both aligned and misaligned offsets, so that each antecedent occurs with each relevant companion value.

// File: rtl/ldx_pkg.sv
package ldx_pkg;

  localparam int BUS_W      = 32;
  localparam int NUM_LANES  = BUS_W / 8;
  localparam int LANE_IDX_W = $clog2(NUM_LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } accSize_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic                  misaligned;
    logic                  signFill;
    accSize_e              widthSel;
    logic [LANE_IDX_W-1:0] baseLane;
    logic [NUM_LANES-1:0]  strobe;
  } laneCtl_t;

endpackage

// File: rtl/ldx_ctrl.sv
module ldx_ctrl
  import ldx_pkg::*;
(
  input  logic [1:0]            accSize,
  input  logic                  signedLoad,
  input  logic [LANE_IDX_W-1:0] addrLow,
  input  logic                  bigEndian,
  output laneCtl_t              ctl
);

  logic [LANE_IDX_W-1:0] spanM1;   // bytes in the access minus one
  logic [NUM_LANES-1:0]  sizeMask;
  logic                  badAlign;
  logic [LANE_IDX_W-1:0] base;
  accSize_e              sizeCode;

  always_comb begin
    sizeCode = accSize_e'(accSize);
    unique case (sizeCode)
      SZ_BYTE: begin
        spanM1   = LANE_IDX_W'(0);
        sizeMask = NUM_LANES'(1);
        badAlign = 1'b0;
      end
      SZ_HALF: begin
        spanM1   = LANE_IDX_W'(1);
        sizeMask = NUM_LANES'(3);
        badAlign = addrLow[0];
      end
      SZ_WORD: begin
        spanM1   = LANE_IDX_W'(NUM_LANES - 1);
        sizeMask = '1;
        badAlign = |addrLow;
      end
      default: begin
        spanM1   = LANE_IDX_W'(NUM_LANES - 1);
        sizeMask = '1;
        badAlign = 1'b1;
      end
    endcase

    // Lane of the least significant byte of the item (R3)
    if (bigEndian)
      base = LANE_IDX_W'(NUM_LANES - 1) - addrLow - spanM1;
    else
      base = addrLow;

    ctl.misaligned = badAlign;
    ctl.signFill   = signedLoad && (sizeCode != SZ_WORD);  // R9
    ctl.widthSel   = sizeCode;
    ctl.baseLane   = base;
    ctl.strobe     = badAlign ? '0 : NUM_LANES'(sizeMask << base);
  end

  // Reserved code must always be flagged (R1, R12)
  always_comb begin
    if (accSize == 2'b11)
      a_r1_reserved_flagged : assert (ctl.misaligned && ctl.strobe == '0);
  end

endmodule

// File: rtl/ldx_datapath.sv
module ldx_datapath
  import ldx_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  laneCtl_t         ctl,
  input  logic [BUS_W-1:0] readData,
  input  logic [BUS_W-1:0] storeData,
  output logic [BUS_W-1:0] loadResult,
  output logic [BUS_W-1:0] storeLanes,
  output logic [NUM_LANES-1:0] byteStrobe,
  output logic             misaligned
);

  localparam int SHIFT_W = LANE_IDX_W + 3;

  logic [SHIFT_W-1:0]   bitShift;
  logic [BUS_W-1:0]     shiftedRd;
  logic [BUS_W-1:0]     widthMask;
  logic                 topBit;
  logic [BUS_W-1:0]     loadNext;
  logic [BUS_W-1:0]     laneMaskBits;
  logic [BUS_W-1:0]     lanesNext;

  assign bitShift = {ctl.baseLane, 3'b000};

  // Widen per-lane strobes into a bit mask
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_laneMask
    assign laneMaskBits[8*g +: 8] = {8{ctl.strobe[g]}};
  end

  always_comb begin
    shiftedRd = readData >> bitShift;
    unique case (ctl.widthSel)
      SZ_BYTE: begin
        widthMask = BUS_W'(8'hFF);
        topBit    = shiftedRd[7];
      end
      SZ_HALF: begin
        widthMask = BUS_W'(16'hFFFF);
        topBit    = shiftedRd[15];
      end
      default: begin
        widthMask = '1;
        topBit    = shiftedRd[BUS_W-1];
      end
    endcase

    if (ctl.misaligned)
      loadNext = '0;
    else
      loadNext = (shiftedRd & widthMask) |
                 ({BUS_W{ctl.signFill && topBit}} & ~widthMask);

    lanesNext = (storeData << bitShift) & laneMaskBits;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadResult <= '0;
      storeLanes <= '0;
      byteStrobe <= '0;
      misaligned <= 1'b0;
    end else begin
      loadResult <= loadNext;
      storeLanes <= lanesNext;
      byteStrobe <= ctl.strobe;
      misaligned <= ctl.misaligned;
    end
  end

  // A flagged access leaves every data output quiet (R12)
  a_r12_quiet_when_flagged : assert property (@(posedge clk) disable iff (!rstN)
    misaligned |-> (byteStrobe == '0 && storeLanes == '0 && loadResult == '0));

  // Lanes that are not strobed carry no data (R11)
  a_r11_unstrobed_lanes_zero : assert property (@(posedge clk) disable iff (!rstN)
    (byteStrobe == '0) |-> (storeLanes == '0));

endmodule

// File: rtl/ldx_align_unit.sv
module ldx_align_unit
  import ldx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  accSize,
  input  logic        signedLoad,
  input  logic [1:0]  addrLow,
  input  logic        bigEndian,
  input  logic [31:0] readData,
  input  logic [31:0] storeData,
  output logic [31:0] loadResult,
  output logic [31:0] storeLanes,
  output logic [3:0]  byteStrobe,
  output logic        misaligned
);

  laneCtl_t ctl;

  ldx_ctrl u_ctrl (
    .accSize    (accSize),
    .signedLoad (signedLoad),
    .addrLow    (addrLow),
    .bigEndian  (bigEndian),
    .ctl        (ctl)
  );

  ldx_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .readData   (readData),
    .storeData  (storeData),
    .loadResult (loadResult),
    .storeLanes (storeLanes),
    .byteStrobe (byteStrobe),
    .misaligned (misaligned)
  );

  // R10: byte access strobes exactly one lane
  a_r10_byte_one_lane : assert property (@(posedge clk) disable iff (!rstN)
    (accSize == 2'b00) |=> ($countones(byteStrobe) == 1));

  // R11: aligned halfword strobes an adjacent lane pair
  a_r11_half_pair : assert property (@(posedge clk) disable iff (!rstN)
    (accSize == 2'b01 && !addrLow[0]) |=> (byteStrobe == 4'b0011 || byteStrobe == 4'b1100));

  // R11: aligned word strobes every lane
  a_r11_word_all_lanes : assert property (@(posedge clk) disable iff (!rstN)
    (accSize == 2'b10 && addrLow == 2'b00) |=> (byteStrobe == 4'b1111));

  // R7: unsigned narrow loads carry zero upper bits
  a_r7_byte_zero_fill : assert property (@(posedge clk) disable iff (!rstN)
    (accSize == 2'b00 && !signedLoad) |=> (loadResult[31:8] == '0));

  a_r7_half_zero_fill : assert property (@(posedge clk) disable iff (!rstN)
    (accSize == 2'b01 && !signedLoad) |=> (loadResult[31:16] == '0));

  // R8: signed byte result has uniform upper bits
  a_r8_byte_sign_copy : assert property (@(posedge clk) disable iff (!rstN)
    (accSize == 2'b00 && signedLoad) |=> (loadResult[31:7] == '0 || loadResult[31:7] == '1));

  // R9: aligned word load passes the bus word through
  a_r9_word_passthrough : assert property (@(posedge clk) disable iff (!rstN)
    (accSize == 2'b10 && addrLow == 2'b00) |=> (loadResult == $past(readData)));

endmodule

// File: tb/ldx_align_unit_bench.sv
module ldx_align_unit_bench;

  typedef struct packed {
    logic [3:0]  tag;
    logic [1:0]  sz;
    logic        sg;
    logic [1:0]  ad;
    logic        be;
    logic [31:0] rd;
    logic [31:0] sd;
    logic [31:0] xLoad;
    logic [31:0] xLanes;
    logic [3:0]  xStb;
    logic        xMis;
  } vec_t;

  localparam int NV = 17;
  localparam logic [31:0] SD = 32'hA1B2C3D4;

  localparam vec_t VECS [NV] = '{
    // R4 big-endian halfwords
    '{4'd4, 2'b01, 1'b0, 2'd0, 1'b1, 32'h12345678, SD, 32'h00001234, 32'hC3D40000, 4'b1100, 1'b0},
    '{4'd4, 2'b01, 1'b0, 2'd2, 1'b1, 32'h12345678, SD, 32'h00005678, 32'h0000C3D4, 4'b0011, 1'b0},
    // R5 little-endian halfwords
    '{4'd5, 2'b01, 1'b0, 2'd0, 1'b0, 32'h78563412, SD, 32'h00003412, 32'h0000C3D4, 4'b0011, 1'b0},
    '{4'd5, 2'b01, 1'b0, 2'd2, 1'b0, 32'h78563412, SD, 32'h00007856, 32'hC3D40000, 4'b1100, 1'b0},
    // R6 same byte either mode, R10 single lane, R3 mapping
    '{4'd6, 2'b00, 1'b0, 2'd1, 1'b0, 32'h78563412, SD, 32'h00000034, 32'h0000D400, 4'b0010, 1'b0},
    '{4'd6, 2'b00, 1'b0, 2'd1, 1'b1, 32'h12345678, SD, 32'h00000034, 32'h00D40000, 4'b0100, 1'b0},
    // R8 signed byte, R7 unsigned byte
    '{4'd8, 2'b00, 1'b1, 2'd3, 1'b0, 32'h80FF0102, SD, 32'hFFFFFF80, 32'hD4000000, 4'b1000, 1'b0},
    '{4'd7, 2'b00, 1'b0, 2'd3, 1'b0, 32'h80FF0102, SD, 32'h00000080, 32'hD4000000, 4'b1000, 1'b0},
    // R8 signed halfword negative and positive
    '{4'd8, 2'b01, 1'b1, 2'd0, 1'b1, 32'h80FF0102, SD, 32'hFFFF80FF, 32'hC3D40000, 4'b1100, 1'b0},
    '{4'd8, 2'b01, 1'b1, 2'd2, 1'b0, 32'h7FFF8001, SD, 32'h00007FFF, 32'hC3D40000, 4'b1100, 1'b0},
    // R9 word loads ignore signedLoad and endianness; R11 all lanes
    '{4'd9, 2'b10, 1'b1, 2'd0, 1'b0, 32'h87654321, SD, 32'h87654321, SD,           4'b1111, 1'b0},
    '{4'd9, 2'b10, 1'b1, 2'd0, 1'b1, 32'hF0000001, SD, 32'hF0000001, SD,           4'b1111, 1'b0},
    // R3 big-endian offset 0 is lane 3
    '{4'd3, 2'b00, 1'b1, 2'd0, 1'b1, 32'h7F000080, SD, 32'h0000007F, 32'hD4000000, 4'b1000, 1'b0},
    // R12 misaligned halfword, word, reserved code (R1)
    '{4'd12, 2'b01, 1'b0, 2'd1, 1'b0, 32'h12345678, SD, 32'h00000000, 32'h00000000, 4'b0000, 1'b1},
    '{4'd12, 2'b10, 1'b0, 2'd2, 1'b1, 32'h12345678, SD, 32'h00000000, 32'h00000000, 4'b0000, 1'b1},
    '{4'd1, 2'b11, 1'b0, 2'd0, 1'b0, 32'h12345678, SD, 32'h00000000, 32'h00000000, 4'b0000, 1'b1},
    // R10 little-endian byte store lane 2
    '{4'd10, 2'b00, 1'b1, 2'd2, 1'b0, 32'h00800000, SD, 32'hFFFFFF80, 32'h00D40000, 4'b0100, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  accSize = '0;
  logic        signedLoad = 1'b0;
  logic [1:0]  addrLow = '0;
  logic        bigEndian = 1'b0;
  logic [31:0] readData = '0;
  logic [31:0] storeData = '0;
  logic [31:0] loadResult;
  logic [31:0] storeLanes;
  logic [3:0]  byteStrobe;
  logic        misaligned;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  ldx_align_unit u_ldx_align_unit (
    .clk        (clk),
    .rstN       (rstN),
    .accSize    (accSize),
    .signedLoad (signedLoad),
    .addrLow    (addrLow),
    .bigEndian  (bigEndian),
    .readData   (readData),
    .storeData  (storeData),
    .loadResult (loadResult),
    .storeLanes (storeLanes),
    .byteStrobe (byteStrobe),
    .misaligned (misaligned)
  );

  task automatic checkOut(input string req, input logic [31:0] xl, input logic [31:0] xs,
                          input logic [3:0] xb, input logic xm);
    checks++;
    if (loadResult !== xl || storeLanes !== xs || byteStrobe !== xb || misaligned !== xm) begin
      fails++;
      $display("FAIL %s: got load=%h lanes=%h stb=%b mis=%b, expected load=%h lanes=%h stb=%b mis=%b",
               req, loadResult, storeLanes, byteStrobe, misaligned, xl, xs, xb, xm);
    end
  endtask

  task automatic drive(input logic [1:0] sz, input logic sg, input logic [1:0] ad,
                       input logic be, input logic [31:0] rd, input logic [31:0] sd);
    accSize = sz; signedLoad = sg; addrLow = ad; bigEndian = be;
    readData = rd; storeData = sd;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    finishRun();
  end

  initial begin
    // R2: reset holds outputs at zero despite active inputs
    @(negedge clk);
    drive(2'b10, 1'b0, 2'd0, 1'b0, 32'hDEADBEEF, 32'hCAFEF00D);
    @(posedge clk); #1;
    checkOut("R2 reset state", 32'h0, 32'h0, 4'b0000, 1'b0);
    @(negedge clk);
    rstN = 1'b1;

    // Vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i].sz, VECS[i].sg, VECS[i].ad, VECS[i].be, VECS[i].rd, VECS[i].sd);
      @(posedge clk); #1;
      checkOut($sformatf("R%0d vector %0d", VECS[i].tag, i),
               VECS[i].xLoad, VECS[i].xLanes, VECS[i].xStb, VECS[i].xMis);
    end

    // R2: one-cycle latency, old result held until the next edge
    @(negedge clk);
    drive(2'b00, 1'b0, 2'd0, 1'b0, 32'h000000AA, 32'h00000055);
    @(posedge clk); #1;
    checkOut("R2 latency setup", 32'h000000AA, 32'h00000055, 4'b0001, 1'b0);
    @(negedge clk);
    drive(2'b10, 1'b0, 2'd0, 1'b1, 32'h11223344, 32'h55667788);
    #1;
    checkOut("R2 held before edge", 32'h000000AA, 32'h00000055, 4'b0001, 1'b0);
    @(posedge clk); #1;
    checkOut("R2 updated after edge", 32'h11223344, 32'h55667788, 4'b1111, 1'b0);

    // R11: big-endian halfword store at offset 2 uses lanes 1:0
    @(negedge clk);
    drive(2'b01, 1'b1, 2'd2, 1'b1, 32'h0000FFFE, 32'h0000BEEF);
    @(posedge clk); #1;
    checkOut("R11 BE half lanes", 32'hFFFFFFFE, 32'h0000BEEF, 4'b0011, 1'b0);

    // R12: misaligned word at offset 1 with signed set
    @(negedge clk);
    drive(2'b10, 1'b1, 2'd1, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF);
    @(posedge clk); #1;
    checkOut("R12 word offset 1", 32'h0, 32'h0, 4'b0000, 1'b1);

    // R2: asynchronous reset mid-run clears outputs
    @(negedge clk);
    drive(2'b10, 1'b0, 2'd0, 1'b0, 32'h12121212, 32'h34343434);
    @(posedge clk); #1;
    rstN = 1'b0;
    #1;
    checkOut("R2 mid-run reset", 32'h0, 32'h0, 4'b0000, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    checkOut("R2 after reset release", 32'h12121212, 32'h34343434, 4'b1111, 1'b0);

    finishRun();
  end

endmodule